// File: doc/BRIEF.md
# Quaternary Short Scrambling Code Generator

This block produces the complex uplink short scrambling code that belongs to a 24-bit code number. Three 8-stage recursions run side by side. One works over the integers modulo 4 and gives a(i). Two are binary and give b(i) and d(i). Each chip value is z(i) = a(i) + 2b(i) + 2d(i) mod 4. The recursions make 255 chips. A 256th chip then repeats the first value, so the code has a period of 256 chips.

Each quaternary chip value becomes two real signs. These are combined into an in-phase and a quadrature sign for every chip. The quadrature sign of an odd chip reuses the second sign of the even chip just before it. The pattern repeats every 256 chips across a frame of 38400 chips. The block marks the first chip of every period and the first chip of the frame.

A one-cycle load strobe captures the code number and restarts the code at chip 0. After that, every cycle with chip enable high moves the outputs on by one chip. When a period ends, the generator reseeds itself from the code number it captured at load time.

Top module: `short_scrambler`

## Requirements
- R1: During and after a synchronous active-low reset, with no load yet, the block shows chip 0 of code number 0. Both signs are negative (out_i = 1, out_q = 1), and period_start and frame_start are both 1.
- R2: A load captures code_num and shows chip 0 of that code in the next cycle, with period_start and frame_start both 1. A load takes priority over chip_en when both are high in the same cycle.
- R3: In a cycle with chip_en low and load low, all four outputs keep their values into the next cycle.
- R4: Chip i (0..254) uses z(i) = a(i)+2b(i)+2d(i) mod 4. The seeds are a(0) = 2·n0+1, a(k) = 2·nk for k = 1..7, b(k) = n(8+k) and d(k) = n(16+k). The updates are a(i) = 3a(i−3)+a(i−5)+3a(i−6)+2a(i−7)+3a(i−8) mod 4, b(i) = b(i−1)^b(i−3)^b(i−7)^b(i−8) and d(i) = d(i−1)^d(i−3)^d(i−4)^d(i−8).
- R5: out_i is 1 (meaning −1) exactly when the chip's z is 1 or 2, and 0 (meaning +1) when z is 0 or 3.
- R6: The second sign c2 is negative when z is 2 or 3. out_q = c1 XOR c2 on an even chip. On an odd chip, out_q = c1 XOR 1 XOR c2 of the preceding even chip.
- R7: Chip 255 of every period repeats the z of chip 0. period_start is 1 exactly on chip 0 of each 256-chip period.
- R8: frame_start is 1 exactly on chip 0 of a 38400-chip frame, which is always also a period start. After chip 38399 the code restarts at chip 0.
- R9: After chip 255 the registers reseed from the code number captured at the last load. A change on code_num with load low has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock |
| rst_n | input | 1 | Synchronous reset, active low |
| code_num | input | 24 | Code number, bit 0 is n0 |
| load | input | 1 | Capture code_num and restart at chip 0 |
| chip_en | input | 1 | Advance one chip |
| out_i | output | 1 | In-phase sign, 1 = −1 |
| out_q | output | 1 | Quadrature sign, 1 = −1 |
| period_start | output | 1 | Current chip is chip 0 of a period |
| frame_start | output | 1 | Current chip is chip 0 of the frame |

## Verification
Two things can fall on the same clock edge: a load, and a chip advance, which at the end of a period is also an automatic reseed. The bench drives load together with chip_en high, once at the start and again in the middle of runs where the chip index is arbitrary. The expected result is that the new code starts at chip 0 and the advance is ignored. A separate stretch changes code_num without a load while the end of each period forces a reseed. There the outputs must keep following the code that was captured earlier. A reference model in the bench builds each sequence straight from the recursions and checks every output on every cycle.

// File: rtl/short_scr_pkg.sv
// Shared constants, types and helper functions for the short scrambling generator.
// Assumes the fixed 8-stage recursions and a 24-bit code number.
package short_scr_pkg;
    localparam int LFSR_N     = 8;
    localparam int CODE_W     = 3 * LFSR_N;
    localparam int SEQ_PERIOD = 256;
    localparam int PHASE_W    = $clog2(SEQ_PERIOD);

    typedef logic [1:0] z4_t;

    // Product modulo 4 of a stage value and a constant coefficient.
    function automatic z4_t z4_mul(input z4_t v, input z4_t c);
        logic [3:0] p;
        p = {2'b00, v} * {2'b00, c};
        return p[1:0];
    endfunction

    // First real sign: negative for z = 1 or 2.
    function automatic logic c1_neg(input z4_t z);
        return z[1] ^ z[0];
    endfunction

    // Second real sign: negative for z = 2 or 3.
    function automatic logic c2_neg(input z4_t z);
        return z[1];
    endfunction
endpackage

// File: rtl/short_scr_z4_lfsr.sv
// Shift register over Z4: N two-bit stages, stage 0 holds the oldest symbol.
// The new symbol is the sum mod 4 of each stage times its constant coefficient.
// Assumes the caller gives seed_en priority over step_en.
module short_scr_z4_lfsr
    import short_scr_pkg::*;
#(
    parameter int               N        = 8,
    parameter logic [2*N-1:0]   COEF     = 16'h0C7B,
    parameter logic [2*N-1:0]   RST_SEED = 16'h0001
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           seed_en,
    input  logic           step_en,
    input  logic [2*N-1:0] seed,
    output z4_t            head
);
    z4_t st   [N];
    z4_t prod [N];
    z4_t fb;

    // One constant multiplier per stage.
    for (genvar k = 0; k < N; k++) begin : g_mul
        assign prod[k] = z4_mul(st[k], COEF[2*k +: 2]);
    end

    // Feedback: sum mod 4 of all weighted stages.
    always_comb begin
        fb = '0;
        for (int k = 0; k < N; k++) fb = fb + prod[k];
    end

    // Reset, reseed, or shift one symbol toward stage 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N; k++) st[k] <= RST_SEED[2*k +: 2];
        end else if (seed_en) begin
            for (int k = 0; k < N; k++) st[k] <= seed[2*k +: 2];
        end else if (step_en) begin
            for (int k = 0; k < N-1; k++) st[k] <= st[k+1];
            st[N-1] <= fb;
        end
    end

    assign head = st[0];
endmodule

// File: rtl/short_scr_bin_lfsr.sv
// Binary shift register: bit 0 holds the oldest symbol. The new bit is the
// XOR of the stages selected by TAPS. Assumes seed_en has priority over step_en.
module short_scr_bin_lfsr #(
    parameter int           N        = 8,
    parameter logic [N-1:0] TAPS     = 8'hA3,
    parameter logic [N-1:0] RST_SEED = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         seed_en,
    input  logic         step_en,
    input  logic [N-1:0] seed,
    output logic         head
);
    logic [N-1:0] st;

    // Reset, reseed, or shift in the tap parity at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)       st <= RST_SEED;
        else if (seed_en) st <= seed;
        else if (step_en) st <= {^(st & TAPS), st[N-1:1]};
    end

    assign head = st[0];
endmodule

// File: rtl/short_scrambler.sv
// Uplink short scrambling code generator. It holds the code number captured at
// load, runs one Z4 and two binary recursions, replays chip 0 as chip 255,
// maps z to I/Q signs and marks period and frame starts.
// Assumes chip_en is one pulse per chip; output sign bit 1 means -1.
module short_scrambler
    import short_scr_pkg::*;
#(
    parameter int FRAME_CHIPS = 38400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_num,
    input  logic              load,
    input  logic              chip_en,
    output logic              out_i,
    output logic              out_q,
    output logic              period_start,
    output logic              frame_start
);
    localparam int FRAME_W = $clog2(FRAME_CHIPS);

    logic [CODE_W-1:0]   code_q;
    logic [PHASE_W-1:0]  phase_q;
    logic [FRAME_W-1:0]  frame_q;
    z4_t                 z0_q;
    logic                c2e_q;

    logic [CODE_W-1:0]   seed_src;
    logic [2*LFSR_N-1:0] a_seed;
    logic                last_phase, last_frame, reseed, step;
    z4_t                 a_head, z_cur, z_out;
    logic                b_head, d_head, c1n, c2n;

    assign seed_src   = load ? code_num : code_q;
    assign last_phase = (phase_q == PHASE_W'(SEQ_PERIOD - 1));
    assign last_frame = (frame_q == FRAME_W'(FRAME_CHIPS - 1));
    assign reseed     = load | (chip_en & (last_phase | last_frame));
    assign step       = chip_en & ~reseed;

    // Z4 seed: stage 0 gets 2*n0+1, the others 2*nk.
    for (genvar k = 0; k < LFSR_N; k++) begin : g_aseed
        if (k == 0) begin : g_first
            assign a_seed[2*k +: 2] = {seed_src[k], 1'b1};
        end else begin : g_rest
            assign a_seed[2*k +: 2] = {seed_src[k], 1'b0};
        end
    end

    short_scr_z4_lfsr #(.N(LFSR_N), .COEF(16'h0C7B), .RST_SEED(16'h0001)) u_a (
        .clk(clk), .rst_n(rst_n), .seed_en(reseed), .step_en(step),
        .seed(a_seed), .head(a_head)
    );

    short_scr_bin_lfsr #(.N(LFSR_N), .TAPS(8'hA3), .RST_SEED(8'h00)) u_b (
        .clk(clk), .rst_n(rst_n), .seed_en(reseed), .step_en(step),
        .seed(seed_src[LFSR_N +: LFSR_N]), .head(b_head)
    );

    short_scr_bin_lfsr #(.N(LFSR_N), .TAPS(8'hB1), .RST_SEED(8'h00)) u_d (
        .clk(clk), .rst_n(rst_n), .seed_en(reseed), .step_en(step),
        .seed(seed_src[2*LFSR_N +: LFSR_N]), .head(d_head)
    );

    // Combine the three heads; chip 255 replays the stored chip-0 value.
    assign z_cur = a_head + {b_head, 1'b0} + {d_head, 1'b0};
    assign z_out = last_phase ? z0_q : z_cur;
    assign c1n   = c1_neg(z_out);
    assign c2n   = c2_neg(z_out);

    // Capture the code number and chip-0 value at load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            z0_q   <= 2'b01;
        end else if (load) begin
            code_q <= code_num;
            z0_q   <= {code_num[0] ^ code_num[LFSR_N] ^ code_num[2*LFSR_N], 1'b1};
        end
    end

    // Chip position within the period and within the frame.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            phase_q <= '0;
            frame_q <= '0;
        end else if (chip_en) begin
            phase_q <= (last_phase || last_frame) ? '0 : phase_q + 1'b1;
            frame_q <= last_frame ? '0 : frame_q + 1'b1;
        end
    end

    // Keep the second sign of the even chip for the odd chip that follows.
    always_ff @(posedge clk) begin
        if (!rst_n)                                c2e_q <= 1'b0;
        else if (chip_en && !load && !phase_q[0])  c2e_q <= c2n;
    end

    assign out_i        = c1n;
    assign out_q        = c1n ^ phase_q[0] ^ (phase_q[0] ? c2e_q : c2n);
    assign period_start = (phase_q == '0);
    assign frame_start  = (frame_q == '0);
endmodule

// File: rtl/short_scrambler_chk.sv
// Port-level property checker for short_scrambler. It counts chips on its own
// from load and chip_en and compares markers and chip-255 replay against them.
module short_scrambler_chk (
    input logic clk,
    input logic rst_n,
    input logic load,
    input logic chip_en,
    input logic out_i,
    input logic out_q,
    input logic period_start,
    input logic frame_start
);
    logic [8:0] cnt;
    logic       i0_q;

    // Independent chip count within the 256-chip period.
    always_ff @(posedge clk) begin
        if (!rst_n || load)  cnt <= '0;
        else if (chip_en)    cnt <= (cnt == 9'd255) ? 9'd0 : cnt + 9'd1;
    end

    // Remember the in-phase sign shown on chip 0.
    always_ff @(posedge clk) begin
        if (!rst_n)          i0_q <= 1'b1;
        else if (cnt == 9'd0) i0_q <= out_i;
    end

    AST_HOLD_WITHOUT_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !chip_en) |=> ($stable(out_i) && $stable(out_q) && $stable(period_start) && $stable(frame_start))); // R3
    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (period_start && frame_start)); // R2
    AST_CHIP255_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == 9'd255) |-> (out_i == i0_q)); // R7
    AST_PERIOD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en && !load && cnt == 9'd255) |=> period_start); // R7
    AST_PERIOD_ONLY_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != 9'd0) |-> !period_start); // R7
    AST_FRAME_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> period_start); // R8
endmodule

bind short_scrambler short_scrambler_chk u_chk (
    .clk(clk), .rst_n(rst_n), .load(load), .chip_en(chip_en),
    .out_i(out_i), .out_q(out_q),
    .period_start(period_start), .frame_start(frame_start)
);

// File: tb/short_scrambler_test.sv
`timescale 1ns/1ps
// Bench: a behavioural model builds each 256-chip sequence from the recursions
// and compares all outputs at every falling edge.
module short_scrambler_test;
    localparam int FRAME = 38400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] code_num = '0;
    logic        load = 1'b0;
    logic        chip_en = 1'b0;
    logic        out_i, out_q, period_start, frame_start;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int zref [256];
    int m_phase = 0;
    int m_frame = 0;

    always #4 clk = ~clk;

    short_scrambler #(.FRAME_CHIPS(FRAME)) uut (
        .clk(clk), .rst_n(rst_n), .code_num(code_num), .load(load),
        .chip_en(chip_en), .out_i(out_i), .out_q(out_q),
        .period_start(period_start), .frame_start(frame_start)
    );

    // Build the 256-chip z sequence of a code straight from its definition.
    task automatic build(input int code);
        int a [255];
        int b [255];
        int d [255];
        for (int i = 0; i < 8; i++) begin
            a[i] = (i == 0) ? (2 * (code & 1) + 1) % 4 : (2 * ((code >> i) & 1)) % 4;
            b[i] = (code >> (8 + i)) & 1;
            d[i] = (code >> (16 + i)) & 1;
        end
        for (int i = 8; i < 255; i++) begin
            a[i] = (3*a[i-3] + a[i-5] + 3*a[i-6] + 2*a[i-7] + 3*a[i-8]) % 4;
            b[i] = (b[i-1] + b[i-3] + b[i-7] + b[i-8]) % 2;
            d[i] = (d[i-1] + d[i-3] + d[i-4] + d[i-8]) % 2;
        end
        for (int i = 0; i < 255; i++) zref[i] = (a[i] + 2*b[i] + 2*d[i]) % 4;
        zref[255] = zref[0];
    endtask

    task automatic check1(input string req, input string scen, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s (%s) chip %0d: actual %0b expected %0b", req, scen, m_phase, act, exp);
        end
    endtask

    // Compare all outputs with the model's current chip.
    task automatic compare(input string scen);
        int  z;
        bit  c1, c2, eq;
        z  = zref[m_phase];
        c1 = (z == 1 || z == 2);
        c2 = (z >= 2);
        if (m_phase % 2 == 0) eq = c1 ^ c2;
        else                  eq = c1 ^ 1'b1 ^ (zref[m_phase-1] >= 2);
        check1("R5", scen, out_i, c1);
        check1("R6", scen, out_q, eq);
        check1("R7", scen, period_start, m_phase == 0);
        check1("R8", scen, frame_start, m_frame == 0);
    endtask

    // Check at the falling edge, drive, then update the model after the rising edge.
    task automatic step(input bit ld, input logic [23:0] cd, input bit en, input string scen);
        @(negedge clk);
        compare(scen);
        load = ld; code_num = cd; chip_en = en;
        @(posedge clk);
        if (ld) begin
            build(int'(cd));
            m_phase = 0;
            m_frame = 0;
        end else if (en) begin
            m_phase = (m_phase + 1) % 256;
            m_frame = (m_frame + 1) % FRAME;
        end
    endtask

    initial begin
        build(0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state shows chip 0 of code 0.
        check1("R1", "reset", out_i, 1'b1);
        check1("R1", "reset", out_q, 1'b1);
        check1("R1", "reset", period_start, 1'b1);
        check1("R1", "reset", frame_start, 1'b1);
        rst_n = 1'b1;
        for (int k = 0; k < 300; k++) step(0, 24'h0, 1, "R1 code0 run");
        // R2: load together with chip_en; load wins.
        step(1, 24'h5A3C71, 1, "R2 load with enable");
        for (int k = 0; k < 600; k++) step(0, 24'h5A3C71, 1, "R4 sequence");
        // R3: enable gaps hold outputs.
        for (int k = 0; k < 400; k++) step(0, 24'h5A3C71, (k % 3) != 0, "R3 enable gaps");
        // R2: load in mid-period with enable high.
        step(1, 24'hFFFFFF, 1, "R2 mid-run load");
        for (int k = 0; k < 520; k++) step(0, 24'hFFFFFF, 1, "R4 all ones");
        // R9: code input moves without load; period reseed uses the latched code.
        for (int k = 0; k < 600; k++) step(0, 24'(k * 7919), 1, "R9 code change ignored");
        step(1, 24'h000000, 0, "R2 load zero");
        for (int k = 0; k < 520; k++) step(0, 24'h123456, 1, "R4 zero code");
        // R8: full frame plus wrap.
        step(1, 24'h9C04E3, 1, "R2 frame load");
        for (int k = 0; k < FRAME + 600; k++) step(0, 24'h9C04E3, 1, "R8 frame wrap");
        @(negedge clk);
        compare("R7 final");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule